// File: doc/BRIEF.md
# Policy-Driven Cache Line Scrubber

This block runs in the background and sweeps an external cache one line at a time, from index 0 up to the last index. It starts a sweep once per scrub period. The period is counted in pulses of an external tick. For each line it reads three things from the cache: the valid bit, the dirty bit and a parity-check result. It then decides whether to issue a scrub command for that line. There are two command types: invalidate-only, which drops a clean line, and flush-and-invalidate, which writes back a dirty line first.

The decision depends on the state of the line and on whether the owning processor is idle or busy. An idle processor lets the scrubber shorten data lifetime aggressively. A busy processor only has clean lines with bad parity removed. A dirty line with bad parity is never commanded, because writing it back would spread the parity fault into memory. Three saturating counters report how many clean lines were scrubbed, how many dirty lines were scrubbed and how many dirty lines with bad parity were left in place during the current sweep.

A small configuration write port loads an enable bit and the period. Out of reset the block is enabled and uses the parameter default period. The chip default is 10000 ticks of a 1 ms tick, which gives ten seconds.

Top module: `cache_scrubber`

## Requirements
- R1: After reset the block is enabled, uses period DEF_PERIOD, has cmd_valid low and sweep_busy low, and reads zero on all three counters.
- R2: Each tick while enabled advances a tick count. The tick that brings the count to the period value ends the period, and the next cycle sweep_busy goes high. A period value of 0 acts as 1.
- R3: A sweep presents lk_idx values 0 up to 2^IDX_W-1 in ascending order, each once, and then drops sweep_busy. cmd_valid is never high while sweep_busy is low.
- R4: With lk_idle high, a valid clean line gets an invalidate-only command (cmd_flush=0), and a valid dirty line with lk_par_ok high gets a flush command (cmd_flush=1).
- R5: With lk_idle low, only a valid clean line with lk_par_ok low gets a command, and it is invalidate-only. All other lines get no command.
- R6: A valid dirty line with lk_par_ok low never gets a command in either mode. Each such line adds one to cnt_skip.
- R7: A line with lk_valid low gets no command and changes no counter.
- R8: A command holds cmd_valid, cmd_idx and cmd_flush steady, and the sweep stays on that line, until a cycle in which cmd_ready is high.
- R9: lk_idle is sampled once per line, in the cycle that line is looked up. A change while the command is waiting does not alter that command.
- R10: cnt_clean counts accepted invalidate commands and cnt_dirty counts accepted flush commands. All counters saturate at 2^CNT_W-1, clear when a sweep starts, and hold their value after the sweep ends.
- R11: A period that ends during a sweep is kept pending. Its sweep starts right after the current sweep ends, and no sweep ever starts while one is running.
- R12: A cycle with cfg_wr high loads cfg_en and cfg_period, clears the tick count and drops any pending start. While the block is disabled, ticks start no sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load enable and period |
| cfg_en | input | 1 | Enable value to load |
| cfg_period | input | PER_W | Period in ticks to load |
| tick | input | 1 | Period time base pulse |
| lk_idle | input | 1 | Owning processor is idle |
| lk_idx | output | IDX_W | Line index being looked up |
| lk_valid | input | 1 | Looked-up line is valid |
| lk_dirty | input | 1 | Looked-up line is dirty |
| lk_par_ok | input | 1 | Looked-up line has good parity |
| cmd_valid | output | 1 | Scrub command offered |
| cmd_ready | input | 1 | Scrub command accepted |
| cmd_flush | output | 1 | 1 flush-and-invalidate, 0 invalidate-only |
| cmd_idx | output | IDX_W | Line index of the command |
| sweep_busy | output | 1 | A sweep is in progress |
| cnt_clean | output | CNT_W | Clean lines scrubbed this sweep |
| cnt_dirty | output | CNT_W | Dirty lines scrubbed this sweep |
| cnt_skip | output | CNT_W | Dirty bad-parity lines skipped this sweep |

## Verification
The bench builds the block with IDX_W=3, CNT_W=2, PER_W=4 and DEF_PERIOD=3. Eight lines is exactly the number of combinations of valid, dirty and parity. One rotated sweep therefore covers the whole decision matrix, and the bench runs every rotation in both idle and busy mode. Uniform sweeps of eight identical lines push the 2-bit counters past their saturation value of 3. The 4-bit period reaches the default, zero and mid-count reconfiguration cases within a few ticks.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_INV   = 2'd1,
    ACT_FLUSH = 2'd2,
    ACT_SKIP  = 2'd3
  } scrub_act_e;

  // Policy matrix: state of the line x processor activity.
  function automatic scrub_act_e scrub_decide(input logic valid, input logic dirty,
                                              input logic par_ok, input logic idle);
    scrub_act_e act;
    act = ACT_NONE;
    if (valid) begin
      if (dirty && !par_ok)   act = ACT_SKIP;   // never written back
      else if (idle)          act = dirty ? ACT_FLUSH : ACT_INV;
      else if (!dirty && !par_ok) act = ACT_INV;
    end
    return act;
  endfunction

endpackage

// File: rtl/scrub_period.sv
module scrub_period #(
  parameter int unsigned PER_W      = 16,
  parameter int unsigned DEF_PERIOD = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             tick,
  input  logic             take,
  output logic             start_req
);

  logic             en_q, en_n;
  logic [PER_W-1:0] per_q, per_n;
  logic [PER_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic [PER_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    en_n   = en_q;
    per_n  = per_q;
    cnt_n  = cnt_q;
    pend_n = pend_q & ~take;
    if (cfg_wr) begin
      en_n   = cfg_en;
      per_n  = cfg_period;
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (!en_q) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, per_q}) begin
        cnt_n  = '0;
        pend_n = 1'b1;
      end else begin
        cnt_n  = cnt_inc[PER_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      per_q  <= PER_W'(DEF_PERIOD);
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      per_q  <= per_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign start_req = pend_q;

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker
  import scrub_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             lk_valid,
  input  logic             lk_dirty,
  input  logic             lk_par_ok,
  input  logic             lk_idle,
  input  logic             cmd_ready,
  output logic             take,
  output logic [IDX_W-1:0] lk_idx,
  output logic             cmd_valid,
  output logic             cmd_flush,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             busy,
  output logic             clr,
  output logic [2:0]       inc
);

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  typedef enum logic [1:0] {ST_WAIT, ST_LOOK, ST_CMD} walk_st_e;

  walk_st_e         st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             fl_q, fl_n;
  scrub_act_e       act;

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    fl_n  = fl_q;
    take  = 1'b0;
    clr   = 1'b0;
    inc   = 3'b000;   // {skip, dirty, clean}
    act   = scrub_decide(lk_valid, lk_dirty, lk_par_ok, lk_idle);
    unique case (st_q)
      ST_WAIT: begin
        if (start_req) begin
          take  = 1'b1;
          clr   = 1'b1;
          idx_n = '0;
          st_n  = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (act == ACT_INV || act == ACT_FLUSH) begin
          fl_n = (act == ACT_FLUSH);
          st_n = ST_CMD;
        end else begin
          inc[2] = (act == ACT_SKIP);
          if (idx_q == LAST_IDX) st_n = ST_WAIT;
          else                   idx_n = idx_q + 1'b1;
        end
      end
      ST_CMD: begin
        if (cmd_ready) begin
          inc[0] = !fl_q;
          inc[1] = fl_q;
          if (idx_q == LAST_IDX) begin
            st_n = ST_WAIT;
          end else begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_LOOK;
          end
        end
      end
      default: st_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      idx_q <= '0;
      fl_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      fl_q  <= fl_n;
    end
  end

  assign lk_idx    = idx_q;
  assign cmd_idx   = idx_q;
  assign cmd_valid = (st_q == ST_CMD);
  assign cmd_flush = fl_q;
  assign busy      = (st_q != ST_WAIT);

endmodule

// File: rtl/scrub_counters.sv
module scrub_counters #(
  parameter int unsigned NUM   = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q, c_n;

    always_comb begin
      c_n = c_q;
      if (clr)                          c_n = '0;
      else if (inc[g] && c_q != CNT_MAX) c_n = c_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_n;
    end

    assign cnt[g] = c_q;
  end

endmodule

// File: rtl/cache_scrubber.sv
module cache_scrubber #(
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PER_W      = 16,
  parameter int unsigned DEF_PERIOD = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             tick,
  input  logic             lk_idle,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             lk_valid,
  input  logic             lk_dirty,
  input  logic             lk_par_ok,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_flush,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             sweep_busy,
  output logic [CNT_W-1:0] cnt_clean,
  output logic [CNT_W-1:0] cnt_dirty,
  output logic [CNT_W-1:0] cnt_skip
);

  localparam int unsigned NUM_CNT = 3;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                          start_req, take, clr;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  scrub_period #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_period (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_period(cfg_period), .tick(tick), .take(take), .start_req(start_req)
  );

  scrub_walker #(.IDX_W(IDX_W)) u_walker (
    .clk(clk), .rst_n(rst_int_n), .start_req(start_req),
    .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_par_ok(lk_par_ok),
    .lk_idle(lk_idle), .cmd_ready(cmd_ready), .take(take), .lk_idx(lk_idx),
    .cmd_valid(cmd_valid), .cmd_flush(cmd_flush), .cmd_idx(cmd_idx),
    .busy(sweep_busy), .clr(clr), .inc(inc)
  );

  scrub_counters #(.NUM(NUM_CNT), .CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .inc(inc), .cnt(cnt)
  );

  assign cnt_clean = cnt[0];
  assign cnt_dirty = cnt[1];
  assign cnt_skip  = cnt[2];

endmodule

// File: rtl/scrub_chk.sv
module scrub_chk #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_idle,
  input logic             lk_valid,
  input logic             lk_dirty,
  input logic             lk_par_ok,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_flush,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             sweep_busy,
  input logic [CNT_W-1:0] cnt_clean,
  input logic [CNT_W-1:0] cnt_dirty,
  input logic [CNT_W-1:0] cnt_skip
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_idx) && $stable(cmd_flush)); // R8

  AST_NO_DIRTY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(lk_valid) && !($past(lk_dirty) && !$past(lk_par_ok))); // R6

  AST_FLUSH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> cmd_flush == $past(lk_dirty)); // R4

  AST_BUSY_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && !$past(lk_idle) |-> !cmd_flush && !$past(lk_par_ok)); // R5

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_busy |-> !cmd_valid); // R3

  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy && $past(sweep_busy) |->
      cnt_clean >= $past(cnt_clean) && cnt_dirty >= $past(cnt_dirty) &&
      cnt_skip >= $past(cnt_skip)); // R10

endmodule

bind cache_scrubber scrub_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_idle(lk_idle), .lk_valid(lk_valid),
  .lk_dirty(lk_dirty), .lk_par_ok(lk_par_ok), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_flush(cmd_flush), .cmd_idx(cmd_idx),
  .sweep_busy(sweep_busy), .cnt_clean(cnt_clean), .cnt_dirty(cnt_dirty),
  .cnt_skip(cnt_skip)
);

// File: tb/cache_scrubber_tb.sv
module cache_scrubber_tb;

  localparam int IDX_W = 3, CNT_W = 2, PER_W = 4, DEF_P = 3;
  localparam int NL = 1 << IDX_W;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b1, tick = 1'b0, lk_idle = 1'b1;
  logic [PER_W-1:0] cfg_period = '0;
  logic [IDX_W-1:0] lk_idx, cmd_idx;
  logic lk_valid, lk_dirty, lk_par_ok, cmd_valid, cmd_flush, sweep_busy;
  logic cmd_ready = 1'b0;
  logic [CNT_W-1:0] cnt_clean, cnt_dirty, cnt_skip;

  logic [2:0] pat [NL];   // {valid, dirty, par_ok}
  assign {lk_valid, lk_dirty, lk_par_ok} = pat[lk_idx];

  cache_scrubber #(.IDX_W(IDX_W), .CNT_W(CNT_W), .PER_W(PER_W), .DEF_PERIOD(DEF_P)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_period(cfg_period),
    .tick(tick), .lk_idle(lk_idle), .lk_idx(lk_idx), .lk_valid(lk_valid),
    .lk_dirty(lk_dirty), .lk_par_ok(lk_par_ok), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_flush(cmd_flush), .cmd_idx(cmd_idx),
    .sweep_busy(sweep_busy), .cnt_clean(cnt_clean), .cnt_dirty(cnt_dirty), .cnt_skip(cnt_skip)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int rdy_mode = 0;   // 0 pseudo-random, 1 low, 2 high
  logic [7:0] lfsr = 8'hA5;
  int nrec = 0;
  int rec_idx [16];
  int rec_fl [16];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready <= (rdy_mode == 0) ? lfsr[0] : (rdy_mode == 2);
  end

  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready && nrec < 16) begin
      rec_idx[nrec] = int'(cmd_idx);
      rec_fl[nrec]  = int'(cmd_flush);
      nrec++;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic cfg(input logic en, input int per);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_en = en; cfg_period = PER_W'(per); end
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 1000 && sweep_busy; k++) @(negedge clk);
  endtask

  function automatic int sat(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  // Runs one sweep with period 1 and compares against the policy.
  task automatic run_sweep(input logic idle, input string tag);
    int en, ec, ed, es;
    logic v, d, p, want;
    nrec = 0;
    lk_idle = idle;
    pulse();
    for (int k = 0; k < 10 && !sweep_busy; k++) @(negedge clk);
    wait_end();
    en = 0; ec = 0; ed = 0; es = 0;
    for (int i = 0; i < NL; i++) begin
      {v, d, p} = pat[i];
      want = v && (d ? (idle && p) : (idle || !p));   // R4 R5 R6 R7
      if (v && d && !p) es++;
      if (want) begin
        if (en < nrec) begin
          chk(tag, rec_idx[en], i, "command index");
          chk(tag, rec_fl[en], int'(d), "command flush");
        end
        en++;
        if (d) ed++; else ec++;
      end
    end
    chk(tag, nrec, en, "command count");
    chk("R10", int'(cnt_clean), sat(ec), "cnt_clean");
    chk("R10", int'(cnt_dirty), sat(ed), "cnt_dirty");
    chk("R6", int'(cnt_skip), sat(es), "cnt_skip");
  endtask

  initial begin
    for (int i = 0; i < NL; i++) pat[i] = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(sweep_busy), 0, "sweep_busy");
    chk("R1", int'(cmd_valid), 0, "cmd_valid");
    chk("R1", int'(cnt_clean) + int'(cnt_dirty) + int'(cnt_skip), 0, "counters");
    // R2 default period and enable from reset
    pulse(); pulse();
    repeat (3) @(negedge clk);
    chk("R2", int'(sweep_busy), 0, "busy before period ends");
    pulse();
    @(negedge clk);
    chk("R2", int'(sweep_busy), 1, "busy after DEF_PERIOD ticks");
    begin
      int seen = 0;
      for (int k = 0; k < NL && sweep_busy; k++) begin
        if (int'(lk_idx) == seen) seen++;   // R3 ascending visit
        @(negedge clk);
      end
      chk("R3", seen, NL, "indices visited in order");
    end
    wait_end();
    chk("R3", int'(sweep_busy), 0, "sweep ends");

    cfg(1'b1, 1);
    // R4 R5 R6 R7: every rotation covers all eight line states
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < NL; r++) begin
        for (int i = 0; i < NL; i++) pat[i] = 3'((i + r) % NL);
        run_sweep(m[0], m[0] ? "R4" : "R5");
      end
    // R10 saturation: uniform sweeps
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 8; s++) begin
        for (int i = 0; i < NL; i++) pat[i] = 3'(s);
        run_sweep(m[0], "R10");
      end
    // R8 R9: stalled flush keeps its decision when idle drops
    for (int i = 0; i < NL; i++) pat[i] = 3'b111;
    rdy_mode = 1; nrec = 0; lk_idle = 1'b1;
    pulse();
    for (int k = 0; k < 10 && !cmd_valid; k++) @(negedge clk);
    lk_idle = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", int'(cmd_valid), 1, "cmd_valid held");
    chk("R8", int'(lk_idx), 0, "sweep stalled");
    chk("R9", int'(cmd_flush), 1, "flush kept");
    rdy_mode = 0;
    wait_end();
    chk("R9", nrec, 1, "one command only");
    chk("R9", int'(cnt_dirty), 1, "cnt_dirty");
    // R11 pending period during a sweep
    for (int i = 0; i < NL; i++) pat[i] = 3'b000;
    pulse();
    @(negedge clk);
    pulse();
    wait_end();
    begin
      int again = 0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (sweep_busy) again = 1; end
      chk("R11", again, 1, "pending sweep starts");
    end
    wait_end();
    begin
      int any = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (sweep_busy) any = 1; end
      chk("R11", any, 0, "no extra sweep");
    end
    // R12 disable, reload, count clear, period zero
    cfg(1'b0, 1);
    begin
      int any = 0;
      for (int k = 0; k < 4; k++) begin pulse(); @(negedge clk); if (sweep_busy) any = 1; end
      chk("R12", any, 0, "disabled ticks ignored");
    end
    cfg(1'b1, 2);
    pulse(); @(negedge clk);
    chk("R12", int'(sweep_busy), 0, "period 2 after one tick");
    pulse(); @(negedge clk);
    chk("R12", int'(sweep_busy), 1, "period 2 after two ticks");
    wait_end();
    pulse();
    cfg(1'b1, 2);
    pulse(); @(negedge clk);
    chk("R12", int'(sweep_busy), 0, "write clears tick count");
    pulse(); @(negedge clk);
    chk("R12", int'(sweep_busy), 1, "sweep after full period");
    wait_end();
    cfg(1'b1, 0);
    pulse(); @(negedge clk);
    chk("R2", int'(sweep_busy), 1, "period zero acts as one");
    wait_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule